// File: doc/BRIEF.md
# BT.656 Embedded-Sync Timing Decoder

This block watches an 8-bit multiplexed component video stream, one byte per clock, in which chroma and luma bytes interleave as Cb, Y, Cr, Y. It recovers horizontal, vertical and field timing only from the timing reference codes carried inside the stream. No separate sync pins are used. Each code is four bytes long: a three-byte preamble (0xFF, 0x00, 0x00) and then a status byte.

When a status byte passes its protection check, the decoder updates its F, V and H status flags. A start-of-active code (H=0) marks the start of a line. On picture lines (V=0) it also opens a 1440-sample active window. Inside that window the decoder gives the sample index and the Cb/Y/Cr/Y phase. A status byte that fails the check raises an error pulse and changes no timing state.

The decoder also measures the distance from one start-of-active code to the next. It flags any line whose length does not fit the selected standard. An input selects 525-line/60 Hz lines (1716 clocks) or 625-line/50 Hz lines (1728 clocks).

Top module: `bt656_timing_decoder`

## Requirements
- R1: While reset is held and in the first cycle after it, every output is 0, including the sample index and the phase.
- R2: A code is recognised only when the three bytes before the current byte were 0xFF, 0x00 and 0x00, in that order. Any other 0xFF or 0x00 bytes in the stream have no effect on any output.
- R3: A status byte is valid when its layout {1, F, V, H, P3, P2, P1, P0} (bit 7 down to bit 0) holds, with P3=V^H, P2=F^H, P1=F^V and P0=F^V^H. After a valid status byte, f_flag, v_flag and h_flag show its F, V and H from the next cycle on.
- R4: If a status byte follows the preamble but is not valid (bit 7 is 0 or a protection bit is wrong), code_err is high for exactly one cycle. The flags, line_start, field_start, vid_active and the sample index then behave as if no code had arrived.
- R5: A valid code with H=0 (start of active) makes line_start high for one cycle, in the cycle after its status byte.
- R6: A start-of-active code with V=0 sets vid_active high from the next cycle on. It stays high for 1440 cycles unless R10 ends it sooner. A start-of-active code with V=1 sets vid_active low.
- R7: While vid_active is high, sample_idx counts 0, 1, … 1439, one step per cycle. sample_phase equals sample_idx mod 4, where 0 = Cb, 1 = Y, 2 = Cr and 3 = Y. Whenever vid_active is low, sample_idx is 0.
- R8: At each start-of-active code after the first one since reset, len_err is high for one cycle (together with line_start) if the distance in clocks from the previous start-of-active status byte is not the line length. The line length is 1716 when std_625=0 and 1728 when std_625=1.
- R9: field_start is high for one cycle when a valid code carries an F value different from the held f_flag. This applies only after at least one valid code has arrived since reset.
- R10: A valid code with H=1 (end of active) sets vid_active low and sample_idx to 0 from the next cycle on, even if fewer than 1440 samples have passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| std_625 | input | 1 | Line standard: 0 = 525-line (1716 clocks), 1 = 625-line (1728 clocks) |
| pix_in | input | 8 | Multiplexed video byte |
| vid_active | output | 1 | High while active picture samples are on pix_in |
| h_flag | output | 1 | H bit of the last valid code |
| v_flag | output | 1 | V bit of the last valid code |
| f_flag | output | 1 | F (field) bit of the last valid code |
| line_start | output | 1 | One-cycle pulse after a valid start-of-active code |
| field_start | output | 1 | One-cycle pulse when the field bit changes |
| sample_idx | output | 11 | Index of the current active sample |
| sample_phase | output | 2 | Component phase of the current sample |
| code_err | output | 1 | One-cycle pulse for a corrupted status byte |
| len_err | output | 1 | One-cycle pulse for a wrong line length |

## Verification
The properties assume that codes arrive at least four bytes apart. Any line-start pulse can therefore be traced back to a full preamble that entered after reset. They also assume that the input standard changes only between lines. The stimulus is built from whole lines: an end-of-active code, 0x80/0x10 fill, a start-of-active code and a payload. Payload bytes are generated so that a real preamble never appears by chance, while lone 0xFF bytes and runs of 0x00 are placed in the payload on purpose. Status bytes are corrupted, the line is cut short and the standard is switched only at fixed points in the sequence, so the expected pulse counts are known in advance.

// File: rtl/bt656_pkg.sv
package bt656_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] PRE_HI = 8'hFF;
    localparam logic [BYTE_W-1:0] PRE_LO = 8'h00;

    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } trs_flags_t;

    // Expected protection nibble for a given F/V/H triple
    function automatic logic [3:0] trs_guard(input trs_flags_t fl);
        return {fl.v ^ fl.h, fl.f ^ fl.h, fl.f ^ fl.v, fl.f ^ fl.v ^ fl.h};
    endfunction

endpackage

// File: rtl/bt656_trs_detect.sv
module bt656_trs_detect
    import bt656_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] pix_in,
    output logic              code_ok,
    output logic              code_bad,
    output trs_flags_t        code_flags
);

    localparam int HIST = 3;

    typedef struct packed {
        logic [HIST-1:0][BYTE_W-1:0] hist;   // [0] newest
    } det_state_t;

    det_state_t st_d, st_q;
    logic       preamble;
    logic       guard_ok;

    always_comb begin
        st_d = st_q;
        for (int i = HIST - 1; i > 0; i--) begin
            st_d.hist[i] = st_q.hist[i-1];
        end
        st_d.hist[0] = pix_in;

        preamble   = (st_q.hist[2] == PRE_HI) &&
                     (st_q.hist[1] == PRE_LO) &&
                     (st_q.hist[0] == PRE_LO);
        code_flags = trs_flags_t'(pix_in[6:4]);
        guard_ok   = pix_in[7] && (pix_in[3:0] == trs_guard(code_flags));
        code_ok    = preamble && guard_ok;
        code_bad   = preamble && !guard_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/bt656_line_meter.sv
module bt656_line_meter #(
    parameter int LEN_525 = 1716,
    parameter int LEN_625 = 1728
) (
    input  logic clk,
    input  logic rst_n,
    input  logic std_625,
    input  logic sav_ok,
    output logic line_start,
    output logic len_err
);

    localparam int LEN_MAX = (LEN_525 > LEN_625) ? LEN_525 : LEN_625;
    localparam int CNT_W   = $clog2(2 * LEN_MAX + 1);
    localparam logic [CNT_W-1:0] TGT_A = CNT_W'(LEN_525);
    localparam logic [CNT_W-1:0] TGT_B = CNT_W'(LEN_625);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             seen;
        logic             start;
        logic             err;
    } meter_state_t;

    meter_state_t st_d, st_q;
    logic [CNT_W-1:0] target;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.err   = 1'b0;
        target     = std_625 ? TGT_B : TGT_A;

        if (st_q.cnt != {CNT_W{1'b1}}) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end

        if (sav_ok) begin
            st_d.start = 1'b1;
            st_d.err   = st_q.seen && (st_q.cnt != target);
            st_d.seen  = 1'b1;
            st_d.cnt   = CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_start = st_q.start;
    assign len_err    = st_q.err;

endmodule

// File: rtl/bt656_active_track.sv
module bt656_active_track #(
    parameter int SAMPLES = 1440,
    parameter int LANES   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sav_ok,
    input  logic                       sav_blank,
    input  logic                       eav_ok,
    output logic                       active,
    output logic [$clog2(SAMPLES)-1:0] idx,
    output logic [$clog2(LANES)-1:0]   phase
);

    localparam int IDX_W = $clog2(SAMPLES);
    localparam int PH_W  = $clog2(LANES);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(SAMPLES - 1);

    typedef struct packed {
        logic             active;
        logic [IDX_W-1:0] idx;
    } act_state_t;

    act_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sav_ok) begin
            st_d.active = !sav_blank;
            st_d.idx    = '0;
        end else if (eav_ok) begin
            st_d.active = 1'b0;
            st_d.idx    = '0;
        end else if (st_q.active) begin
            if (st_q.idx == LAST) begin
                st_d.active = 1'b0;
                st_d.idx    = '0;
            end else begin
                st_d.idx = st_q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.active;
    assign idx    = st_q.idx;
    assign phase  = st_q.idx[PH_W-1:0];

endmodule

// File: rtl/bt656_timing_decoder.sv
module bt656_timing_decoder
    import bt656_pkg::*;
#(
    parameter int SAMPLES = 1440,
    parameter int LEN_525 = 1716,
    parameter int LEN_625 = 1728,
    parameter int LANES   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       std_625,
    input  logic [7:0]                 pix_in,
    output logic                       vid_active,
    output logic                       h_flag,
    output logic                       v_flag,
    output logic                       f_flag,
    output logic                       line_start,
    output logic                       field_start,
    output logic [$clog2(SAMPLES)-1:0] sample_idx,
    output logic [$clog2(LANES)-1:0]   sample_phase,
    output logic                       code_err,
    output logic                       len_err
);

    typedef struct packed {
        trs_flags_t flags;
        logic       seen;
        logic       cerr;
        logic       fstart;
    } stat_state_t;

    stat_state_t st_d, st_q;
    logic        code_ok;
    logic        code_bad;
    trs_flags_t  code_flags;
    logic        sav_ok;
    logic        eav_ok;

    bt656_trs_detect u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_in     (pix_in),
        .code_ok    (code_ok),
        .code_bad   (code_bad),
        .code_flags (code_flags)
    );

    assign sav_ok = code_ok && !code_flags.h;
    assign eav_ok = code_ok &&  code_flags.h;

    bt656_line_meter #(
        .LEN_525 (LEN_525),
        .LEN_625 (LEN_625)
    ) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .std_625    (std_625),
        .sav_ok     (sav_ok),
        .line_start (line_start),
        .len_err    (len_err)
    );

    bt656_active_track #(
        .SAMPLES (SAMPLES),
        .LANES   (LANES)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .sav_ok    (sav_ok),
        .sav_blank (code_flags.v),
        .eav_ok    (eav_ok),
        .active    (vid_active),
        .idx       (sample_idx),
        .phase     (sample_phase)
    );

    always_comb begin
        st_d        = st_q;
        st_d.cerr   = code_bad;
        st_d.fstart = 1'b0;
        if (code_ok) begin
            st_d.fstart = st_q.seen && (code_flags.f != st_q.flags.f);
            st_d.flags  = code_flags;
            st_d.seen   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign h_flag      = st_q.flags.h;
    assign v_flag      = st_q.flags.v;
    assign f_flag      = st_q.flags.f;
    assign code_err    = st_q.cerr;
    assign field_start = st_q.fstart;

endmodule

// File: rtl/bt656_timing_checker.sv
module bt656_timing_checker #(
    parameter int SAMPLES = 1440,
    parameter int IDX_W   = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       pix_in,
    input logic             vid_active,
    input logic             h_flag,
    input logic             v_flag,
    input logic             f_flag,
    input logic             line_start,
    input logic             field_start,
    input logic [IDX_W-1:0] sample_idx,
    input logic             code_err,
    input logic             len_err
);

    assert_preamble_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start || code_err) |->
            ($past(pix_in, 2) == 8'h00 && $past(pix_in, 3) == 8'h00 && $past(pix_in, 4) == 8'hFF));

    assert_active_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vid_active |-> (!v_flag && !h_flag));

    assert_bad_code_inert_R4: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |-> ($stable(f_flag) && $stable(v_flag) && $stable(h_flag) && !line_start && !field_start));

    assert_start_is_sav_R5: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |-> !h_flag);

    assert_active_opens_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vid_active) |-> line_start);

    assert_idle_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !vid_active |-> (sample_idx == '0));

    assert_index_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_active && $past(vid_active) && !line_start) |-> (sample_idx == $past(sample_idx) + IDX_W'(1)));

    assert_index_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vid_active |-> (sample_idx < IDX_W'(SAMPLES)));

    assert_len_at_sav_R8: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> line_start);

    assert_field_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |-> (f_flag != $past(f_flag)));

    assert_active_close_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vid_active) |-> ($past(sample_idx) == IDX_W'(SAMPLES - 1) || h_flag || line_start));

endmodule

bind bt656_timing_decoder bt656_timing_checker #(
    .SAMPLES (SAMPLES),
    .IDX_W   ($clog2(SAMPLES))
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_in      (pix_in),
    .vid_active  (vid_active),
    .h_flag      (h_flag),
    .v_flag      (v_flag),
    .f_flag      (f_flag),
    .line_start  (line_start),
    .field_start (field_start),
    .sample_idx  (sample_idx),
    .code_err    (code_err),
    .len_err     (len_err)
);

// File: tb/bt656_timing_decoder_tb.sv
module bt656_timing_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        std_625 = 1'b0;
    logic [7:0]  pix_in = 8'h00;
    logic        vid_active, h_flag, v_flag, f_flag;
    logic        line_start, field_start, code_err, len_err;
    logic [10:0] sample_idx;
    logic [1:0]  sample_phase;

    always #5 clk = ~clk;

    bt656_timing_decoder u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .std_625      (std_625),
        .pix_in       (pix_in),
        .vid_active   (vid_active),
        .h_flag       (h_flag),
        .v_flag       (v_flag),
        .f_flag       (f_flag),
        .line_start   (line_start),
        .field_start  (field_start),
        .sample_idx   (sample_idx),
        .sample_phase (sample_phase),
        .code_err     (code_err),
        .len_err      (len_err)
    );

    int n_checks = 0;
    int n_errs   = 0;
    bit finished = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int  hist[$];
    int  cyc;
    int  last_sav;
    bit  m_act, m_f, m_v, m_h, m_seen, m_ls, m_le, m_ce, m_fs;
    int  m_idx;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = {};
            cyc = 0; last_sav = -1;
            m_act = 0; m_idx = 0; m_f = 0; m_v = 0; m_h = 0; m_seen = 0;
            m_ls = 0; m_le = 0; m_ce = 0; m_fs = 0;
        end else begin
            bit took;
            int xy;
            bit f, v, h, good;
            took = 0;
            m_ls = 0; m_le = 0; m_ce = 0; m_fs = 0;
            cyc++;
            xy = int'(pix_in);
            if (hist.size() == 3 && hist[0] == 255 && hist[1] == 0 && hist[2] == 0) begin
                f = xy[6]; v = xy[5]; h = xy[4];
                good = xy[7] && (xy[3] == (v ^ h)) && (xy[2] == (f ^ h)) &&
                       (xy[1] == (f ^ v)) && (xy[0] == (f ^ v ^ h));
                if (!good) begin
                    m_ce = 1;
                end else begin
                    took = 1;
                    if (m_seen && f != m_f) m_fs = 1;
                    m_seen = 1; m_f = f; m_v = v; m_h = h;
                    m_idx = 0;
                    if (!h) begin
                        m_ls = 1;
                        if (last_sav >= 0 && (cyc - last_sav) != (std_625 ? 1728 : 1716)) m_le = 1;
                        last_sav = cyc;
                        m_act = !v;
                    end else begin
                        m_act = 0;
                    end
                end
            end
            if (!took && m_act) begin
                if (m_idx == 1439) begin m_act = 0; m_idx = 0; end
                else m_idx++;
            end
            hist.push_back(xy);
            if (hist.size() > 3) void'(hist.pop_front());
        end
    end

    // ---------------- per-cycle comparison and event counters ----------------
    int cnt_ls = 0, cnt_le = 0, cnt_ce = 0, cnt_fs = 0;
    int act_cycles = 0, act_rises = 0, max_idx = 0;
    bit prev_act = 0;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R6", "vid_active", int'(vid_active), int'(m_act));
            chk("R7", "sample_idx", int'(sample_idx), m_idx);
            chk("R7", "sample_phase", int'(sample_phase), m_idx % 4);
            chk("R3", "f_flag", int'(f_flag), int'(m_f));
            chk("R3", "v_flag", int'(v_flag), int'(m_v));
            chk("R3", "h_flag", int'(h_flag), int'(m_h));
            chk("R5", "line_start", int'(line_start), int'(m_ls));
            chk("R4", "code_err", int'(code_err), int'(m_ce));
            chk("R8", "len_err", int'(len_err), int'(m_le));
            chk("R9", "field_start", int'(field_start), int'(m_fs));
            cnt_ls += int'(line_start);
            cnt_le += int'(len_err);
            cnt_ce += int'(code_err);
            cnt_fs += int'(field_start);
            if (vid_active) act_cycles++;
            if (vid_active && !prev_act) act_rises++;
            if (int'(sample_idx) > max_idx) max_idx = int'(sample_idx);
            prev_act = vid_active;
        end
    end

    // ---------------- stimulus ----------------
    function automatic logic [7:0] status(input bit f, input bit v, input bit h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    function automatic logic [7:0] payload(input int i);
        int k;
        k = i % 97;
        case (k)
            5:  return 8'hFF;
            6:  return 8'h00;
            7:  return 8'h3C;
            20, 21, 22: return 8'h00;
            40, 41: return 8'hFF;
            42: return 8'h00;
            default: return (8'((i * 37) + 11) & 8'h7F) | 8'h01;
        endcase
    endfunction

    task automatic put(input logic [7:0] b);
        @(posedge clk);
        #1 pix_in = b;
    endtask

    task automatic send_code(input logic [7:0] xy);
        put(8'hFF); put(8'h00); put(8'h00); put(xy);
    endtask

    task automatic send_line(input bit f, input bit v, input int act, input int hb,
                             input bit eav_bad, input bit sav_bad);
        send_code(status(f, v, 1'b1) ^ (eav_bad ? 8'h80 : 8'h00));
        for (int i = 0; i < hb; i++) put((i % 2 == 0) ? 8'h80 : 8'h10);
        send_code(status(f, v, 1'b0) ^ (sav_bad ? 8'h01 : 8'h00));
        for (int i = 0; i < act; i++) put(payload(i));
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1", "vid_active in reset", int'(vid_active), 0);
        chk("R1", "sample_idx in reset", int'(sample_idx), 0);
        chk("R1", "sample_phase in reset", int'(sample_phase), 0);
        chk("R1", "flags in reset", int'({f_flag, v_flag, h_flag}), 0);
        chk("R1", "pulses in reset", int'({line_start, field_start, code_err, len_err}), 0);
        @(posedge clk);
        #1 rst_n = 1'b1;

        send_line(0, 1, 1440, 268, 0, 0);   // L1 blank, first SAV
        send_line(0, 0, 1440, 268, 0, 0);   // L2
        send_line(0, 0, 1440, 268, 0, 0);   // L3
        send_line(0, 0, 1440, 268, 0, 1);   // L4 corrupted SAV
        send_line(0, 0, 1440, 268, 0, 0);   // L5 double-length spacing
        send_line(0, 0, 1000, 268, 0, 0);   // L6 cut short
        send_line(1, 1, 1440, 268, 0, 0);   // L7 field change, short spacing
        send_line(1, 0, 1440, 268, 1, 0);   // L8 corrupted EAV
        @(posedge clk);
        #1 std_625 = 1'b1;
        pix_in = 8'h80;
        // the extra fill byte above is absorbed by using 279 fill bytes next
        send_line(1, 0, 1440, 279, 0, 0);   // L9 625-line spacing
        send_line(0, 0, 1440, 280, 0, 0);   // L10 field change
        send_line(0, 0, 1440, 268, 0, 0);   // L11 wrong length for 625
        send_code(status(0, 0, 1'b1));
        for (int i = 0; i < 20; i++) put((i % 2 == 0) ? 8'h80 : 8'h10);
        @(negedge clk);

        chk("R5", "line_start total", cnt_ls, 10);
        chk("R8", "len_err total", cnt_le, 3);
        chk("R4", "code_err total", cnt_ce, 2);
        chk("R2", "code_err total with stray FF/00 payload", cnt_ce, 2);
        chk("R9", "field_start total", cnt_fs, 2);
        chk("R6", "active cycle total", act_cycles, 7 * 1440 + 1004);
        chk("R6", "active window openings", act_rises, 8);
        chk("R7", "largest sample index", max_idx, 1439);
        chk("R10", "final vid_active after EAV", int'(vid_active), 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000 && !finished) begin
            finished = 1;
            n_checks++;
            n_errs++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 100000);
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

endmodule